// File: doc/BRIEF.md
# Dataway Command Cycle Sequencer

This block sits between a byte-wide host bus and a crate dataway. The host loads a command one byte at a time: three bytes of the 24-bit write word, then the subaddress, the function code, the station number and a control byte. A write to the start address then runs exactly one dataway cycle. The block holds the station, subaddress, function and write word steady on its outputs. During the cycle it raises busy, waits a programmable settling time, and drives two strobe phases. At the end of the first strobe it captures the read word and the Q and X responses.

The host reads back the captured responses, the three read-data bytes and a status byte. The 23 look-at-me request lines are priority encoded into a station number that shares a register with Q and X. When the block is switched offline, a start request does nothing. The host bus is a plain synchronous register port: a transfer happens on any clock edge where the active-low select is low, and the direction line chooses between read and write.

Top module: `dataway_cmd_seq`

## Requirements
- R1: A write to address 0, 1 or 2 loads bits 23:16, 15:8 or 7:0 of `dw_wdat` from `host_wdata`, visible from the clock after the write.
- R2: A write to address 3 loads `dw_sub` from data bits 3:0. A write to address 4 loads `dw_fn` from bits 4:0. A write to address 5 loads `dw_stn` from bits 4:0.
- R3: A write to address 6 sets Z (bit 0), C (bit 1), inhibit (bit 2) and auxiliary hold (bit 3), driven on `dw_z`, `dw_c`, `dw_inh` and `dw_aux_hold`. Z and C clear themselves on the edge that ends the next dataway cycle. Inhibit and hold keep their value.
- R4: A write to address 7, while online and idle, starts a cycle, and `dw_busy` is high from the next clock.
- R5: A cycle lasts WAIT_CYC+2*STB_CYC+1 clocks of `dw_busy`. It runs WAIT_CYC clocks with no strobe, then STB_CYC clocks of `dw_s1`, then STB_CYC clocks of `dw_s2`, then one release clock. The two strobes are never high together.
- R6: `dw_rdat`, `dw_q` and `dw_x` are sampled on the last clock of `dw_s1`. Address 8 returns Q in bit 7 and X in bit 6. Addresses 9, 10 and 11 return read bits 23:16, 15:8 and 7:0.
- R7: Address 12 returns cycle complete in bit 0, `grant_in` in bit 1 and the online state (not `offline`) in bit 2, with zeros elsewhere. Cycle complete is 0 after reset, clears when a cycle starts and sets when it ends.
- R8: While `offline` is high, a write to address 7 starts no cycle and leaves cycle complete unchanged.
- R9: A write to address 7 during a cycle is ignored, and the running cycle keeps its length.
- R10: Address 8 bits 4:0 hold the lowest active station number, where `dw_lam[0]` is station 1 and `dw_lam[22]` is station 23. Bit 5 is set when any request line is high. Both fields read zero when no line is high.
- R11: With `host_sel_n` high, no write takes effect and `host_rdata` is zero. Reads of addresses 0–7 and 13–15 return zero. Writes to 13–15 change nothing.
- R12: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel_n | input | 1 | Active-low host select |
| host_rd | input | 1 | 1 = read, 0 = write |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (zero when not reading) |
| offline | input | 1 | Suppresses dataway cycles |
| grant_in | input | 1 | Auxiliary-controller grant state |
| dw_stn | output | 5 | Station number |
| dw_sub | output | 4 | Subaddress |
| dw_fn | output | 5 | Function code |
| dw_wdat | output | 24 | Write word |
| dw_z | output | 1 | Initialize command |
| dw_c | output | 1 | Clear command |
| dw_inh | output | 1 | Inhibit |
| dw_aux_hold | output | 1 | Auxiliary inhibit hold |
| dw_busy | output | 1 | Cycle in progress |
| dw_s1 | output | 1 | First strobe |
| dw_s2 | output | 1 | Second strobe |
| dw_rdat | input | 24 | Read word from dataway |
| dw_q | input | 1 | Q response |
| dw_x | input | 1 | X response |
| dw_lam | input | LAM_W | Request lines, bit 0 = station 1 |

## Verification
The bench builds the block with WAIT_CYC=2 and STB_CYC=2. At these values each strobe lasts longer than one clock, so the capture point at the last strobe-1 clock can be told apart from the first one. The total cycle length of seven clocks leaves room to issue a second start in the middle of a cycle. The request lines keep the default width of 23, so the bench can drive both the lowest and the highest station.

// File: rtl/dataway_cmd_seq.sv
module dataway_cmd_seq #(
  parameter int WAIT_CYC = 4,
  parameter int STB_CYC  = 2,
  parameter int LAM_W    = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_sel_n,
  input  logic             host_rd,
  input  logic [3:0]       host_addr,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  input  logic             offline,
  input  logic             grant_in,
  output logic [4:0]       dw_stn,
  output logic [3:0]       dw_sub,
  output logic [4:0]       dw_fn,
  output logic [23:0]      dw_wdat,
  output logic             dw_z,
  output logic             dw_c,
  output logic             dw_inh,
  output logic             dw_aux_hold,
  output logic             dw_busy,
  output logic             dw_s1,
  output logic             dw_s2,
  input  logic [23:0]      dw_rdat,
  input  logic             dw_q,
  input  logic             dw_x,
  input  logic [LAM_W-1:0] dw_lam
);
  localparam int CMAX  = (WAIT_CYC > STB_CYC) ? WAIT_CYC : STB_CYC;
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam int ENC_W = $clog2(LAM_W + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_WAIT, ST_S1, ST_S2, ST_REL} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [23:0]      rd_word;
  logic             rq, rx, done;
  logic [ENC_W-1:0] lam_num;
  logic             lam_any;

  wire wr_en   = !host_sel_n && !host_rd;
  wire start   = wr_en && host_addr == 4'd7;
  wire wait_end = cnt == CNT_W'(WAIT_CYC - 1);
  wire stb_end  = cnt == CNT_W'(STB_CYC - 1);

  assign dw_busy = st != ST_IDLE;
  assign dw_s1   = st == ST_S1;
  assign dw_s2   = st == ST_S2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      cnt <= '0;
      done <= 1'b0;
      rd_word <= '0;
      rq <= 1'b0;
      rx <= 1'b0;
      dw_wdat <= '0;
      dw_sub <= '0;
      dw_fn <= '0;
      dw_stn <= '0;
      dw_z <= 1'b0;
      dw_c <= 1'b0;
      dw_inh <= 1'b0;
      dw_aux_hold <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start && !offline) begin
          st <= ST_WAIT;
          cnt <= '0;
          done <= 1'b0;
        end
        ST_WAIT: if (wait_end) begin
          st <= ST_S1;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        ST_S1: if (stb_end) begin
          st <= ST_S2;
          cnt <= '0;
          rd_word <= dw_rdat;
          rq <= dw_q;
          rx <= dw_x;
        end else cnt <= cnt + 1'b1;
        ST_S2: if (stb_end) begin
          st <= ST_REL;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        default: begin
          st <= ST_IDLE;
          done <= 1'b1;
          dw_z <= 1'b0;
          dw_c <= 1'b0;
        end
      endcase
      if (wr_en) begin
        case (host_addr)
          4'd0: dw_wdat[23:16] <= host_wdata;
          4'd1: dw_wdat[15:8]  <= host_wdata;
          4'd2: dw_wdat[7:0]   <= host_wdata;
          4'd3: dw_sub <= host_wdata[3:0];
          4'd4: dw_fn  <= host_wdata[4:0];
          4'd5: dw_stn <= host_wdata[4:0];
          4'd6: {dw_aux_hold, dw_inh, dw_c, dw_z} <= host_wdata[3:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    lam_num = '0;
    for (int i = LAM_W - 1; i >= 0; i--)
      if (dw_lam[i]) lam_num = ENC_W'(i + 1);
  end
  assign lam_any = |dw_lam;

  always_comb begin
    host_rdata = '0;
    if (!host_sel_n && host_rd) begin
      case (host_addr)
        4'd8:  host_rdata = {rq, rx, lam_any, 5'(lam_num)};
        4'd9:  host_rdata = rd_word[23:16];
        4'd10: host_rdata = rd_word[15:8];
        4'd11: host_rdata = rd_word[7:0];
        4'd12: host_rdata = {5'd0, !offline, grant_in, done};
        default: host_rdata = '0;
      endcase
    end
  end

  a_r5_s1_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dw_s1) |-> $past(dw_busy) && !$past(dw_s2));
  a_r5_s2_after_s1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dw_s2) |-> $past(dw_s1));
  a_r5_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(dw_s1 && dw_s2));
  a_r7_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dw_busy) |-> host_sel_n || !host_rd || host_addr != 4'd12 || host_rdata[0]);
  a_r3_zc_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dw_busy) && !$past(wr_en && host_addr == 4'd6) |-> !dw_z && !dw_c);
  a_r8_offline_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !dw_busy && offline |=> !dw_busy);
  a_r9_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    dw_s2 && start |=> dw_busy && !dw_s1);
endmodule

// File: tb/tb_dataway_cmd_seq.sv
module tb_dataway_cmd_seq;
  localparam int W = 2, S = 2, LAMN = 23;
  localparam int LEN = W + 2 * S + 1;

  logic clk = 0, rst_n = 0;
  logic sel_n = 1, rd = 1, offl = 0, gnt = 0, q = 0, x = 0;
  logic [3:0] addr = 0;
  logic [7:0] wd = 0, rdata;
  logic [23:0] rword = 0, w_o;
  logic [LAMN-1:0] lam = 0;
  logic [4:0] stn_o, fn_o;
  logic [3:0] sub_o;
  logic z_o, c_o, i_o, h_o, busy_o, s1_o, s2_o;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dataway_cmd_seq #(.WAIT_CYC(W), .STB_CYC(S), .LAM_W(LAMN)) dut (
    .clk(clk), .rst_n(rst_n), .host_sel_n(sel_n), .host_rd(rd), .host_addr(addr),
    .host_wdata(wd), .host_rdata(rdata), .offline(offl), .grant_in(gnt),
    .dw_stn(stn_o), .dw_sub(sub_o), .dw_fn(fn_o), .dw_wdat(w_o), .dw_z(z_o),
    .dw_c(c_o), .dw_inh(i_o), .dw_aux_hold(h_o), .dw_busy(busy_o), .dw_s1(s1_o),
    .dw_s2(s2_o), .dw_rdat(rword), .dw_q(q), .dw_x(x), .dw_lam(lam));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // behavioural reference
  logic [23:0] mw, mr;
  logic [3:0] ma;
  logic [4:0] mf, mn;
  logic mz, mc, mi, mh, mq, mx, mdone;
  int t = -1;

  always @(posedge clk) begin
    if (!rst_n) begin
      mw = 0; mr = 0; ma = 0; mf = 0; mn = 0;
      {mz, mc, mi, mh, mq, mx, mdone} = 0;
      t = -1;
    end else begin
      automatic int t0 = t;
      if (t0 >= 0) begin
        if (t0 == W + S - 1) begin mr = rword; mq = q; mx = x; end
        if (t0 == LEN - 1) begin t = -1; mdone = 1; mz = 0; mc = 0; end
        else t = t0 + 1;
      end
      if (!sel_n && !rd) begin
        case (addr)
          0: mw[23:16] = wd;
          1: mw[15:8] = wd;
          2: mw[7:0] = wd;
          3: ma = wd[3:0];
          4: mf = wd[4:0];
          5: mn = wd[4:0];
          6: {mh, mi, mc, mz} = wd[3:0];
          7: if (t0 < 0 && !offl) begin t = 0; mdone = 0; end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] exp_rd();
    int enc = 0;
    for (int k = LAMN; k >= 1; k--) if (lam[k-1]) enc = k;
    if (sel_n || !rd) return 8'h00;
    case (addr)
      8:  return {mq, mx, enc != 0, 5'(enc)};
      9:  return mr[23:16];
      10: return mr[15:8];
      11: return mr[7:0];
      12: return {5'd0, !offl, gnt, mdone};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_tag();
    if (sel_n || !rd) return "R11";
    case (addr)
      8: return "R10";
      9, 10, 11: return "R6";
      12: return "R7";
      default: return "R11";
    endcase
  endfunction

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R1", w_o, mw);
    chk("R2", {stn_o, fn_o, sub_o}, {mn, mf, ma});
    chk("R3", {z_o, c_o, i_o, h_o}, {mz, mc, mi, mh});
    chk("R5", {busy_o, s1_o, s2_o},
        {t >= 0, t >= W && t < W + S, t >= W + S && t < W + 2 * S});
    chk(rd_tag(), rdata, exp_rd());
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic hwrite(int a, int d);
    tick(); sel_n = 0; rd = 0; addr = 4'(a); wd = 8'(d);
    tick(); sel_n = 1; rd = 1;
  endtask
  task automatic hread(int a);
    tick(); sel_n = 0; rd = 1; addr = 4'(a);
    tick(); sel_n = 1;
  endtask
  task automatic count_busy(output int n);
    n = 0;
    while (busy_o && n < 100) begin n++; tick(); end
  endtask

  initial begin
    int n;
    repeat (3) tick();
    chk("R12", {w_o, stn_o, fn_o, sub_o, z_o, c_o, i_o, h_o, busy_o, s1_o, s2_o}, 0);
    chk("R12", rdata, 0);
    rst_n = 1;
    tick();
    hread(12);
    // R1 R2 R3 loads
    hwrite(0, 8'hA5); hwrite(1, 8'h3C); hwrite(2, 8'h81);
    hwrite(3, 8'hF9); hwrite(4, 8'hFE); hwrite(5, 8'h17); hwrite(6, 8'h0C);
    chk("R1", w_o, 24'hA53C81);
    chk("R2", {sub_o, fn_o, stn_o}, {4'h9, 5'h1E, 5'h17});
    // R4 R5 R6 normal cycle
    rword = 24'h123456; q = 1; x = 0;
    hwrite(7, 0);
    chk("R4", busy_o, 1);
    count_busy(n);
    chk("R5", n, LEN);
    hread(8); hread(9); hread(10); hread(11); gnt = 1; hread(12);
    // R9 start during a cycle
    rword = 24'hFEDCBA; q = 0; x = 1;
    hwrite(7, 0); tick(); hwrite(7, 0);
    count_busy(n);
    chk("R9", n + 3, LEN);
    hread(8); hread(11);
    // R3 Z and C self clear, I and hold persist
    hwrite(6, 8'h0F);
    hwrite(7, 0);
    count_busy(n);
    chk("R3", {z_o, c_o, i_o, h_o}, 4'b0011);
    // R8 offline
    offl = 1;
    hread(12);
    hwrite(7, 0);
    chk("R8", busy_o, 0);
    hread(12);
    offl = 0;
    // R10 request encoding
    lam = 0; hread(8);
    lam = 23'h400000; hread(8);
    lam = 23'h010004; hread(8);
    lam = '1; hread(8);
    lam = 23'h000001; hread(8);
    lam = 0;
    // R11 deselected and unused addresses
    tick(); sel_n = 1; rd = 0; addr = 0; wd = 8'hFF; tick(); rd = 1;
    chk("R11", w_o, 24'hA53C81);
    tick(); sel_n = 1; rd = 1; addr = 8; tick();
    chk("R11", rdata, 0);
    hwrite(13, 8'hFF); hwrite(14, 8'hFF); hwrite(15, 8'hFF);
    for (int a = 0; a < 16; a++) if (a < 8 || a > 12) hread(a);
    repeat (2) tick();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule